// File: doc/BRIEF.md
# Address-Range Register Clear Engine

This controller sits in front of the write port of a register file that is addressed by 12 bits. It owns that port whenever it has work of its own, and it passes host writes through when it is idle. After a synchronous reset it walks two windows, 0x000 to 0x0FF and then 0x400 to 0x5FF. It writes each location with the default value that the register file's default lookup returns for the address being written.

The engine keeps a shadow of the run-control register, which sits at address 0x680. When the host writes exactly 0x0001 to that address while the shadow holds 0x0000, the engine sweeps 0x200 to 0x3FF and writes zero there, one location per clock. Host writes are held off while either walk is active: ready is low and busy is high. The waveform area at 0x800 to 0xFFF is never written by the engine. A clear sweep takes 512 clocks, which fits the 500 µs budget at any clock of 1.03 MHz or faster.

Top module: `reg_clear_engine`

## Requirements
- R1: In the first cycle after reset is released, busy is 1, host_ready is 0, and the write port shows address 0x000 with write enable set.
- R2: After reset the engine writes every address from 0x000 to 0x0FF and then every address from 0x400 to 0x5FF, in ascending order, one per clock, with data equal to dflt_data. Busy falls in the cycle after 0x5FF is written.
- R3: A host write accepted at address 0x680 with data 0x0001, while the run shadow is 0x0000, makes busy rise in the next cycle. The engine then writes 0x0000 to 0x200 through 0x3FF in ascending order, one per clock, which takes 512 cycles, and then busy falls.
- R4: An accepted write to 0x680 does not start a sweep if its data is not 0x0001 or if the shadow is not 0x0000. This covers writing 1 over 1, writing 0, and writing 1 over 2.
- R5: While idle, host_ready is 1, and host_we, host_addr and host_wdata appear unchanged on the write port in the same cycle.
- R6: While busy, host_ready is 0 and host writes have no effect. They do not reach the port and do not change the run shadow.
- R7: The engine never writes an address at or above 0x800.
- R8: The shadow follows every accepted write to 0x680, so a write of 0 followed by a write of 1 starts a new sweep after an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the default restore |
| host_we | input | 1 | Host write request |
| host_addr | input | 12 | Host write address |
| host_wdata | input | 16 | Host write data |
| host_ready | output | 1 | Host write is accepted this cycle |
| dflt_data | input | 16 | Default value for rf_waddr, from a combinational lookup |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 12 | Register file write address |
| rf_wdata | output | 16 | Register file write data |
| busy | output | 1 | Restore or clear walk in progress |

## Verification
Two events can meet in the same cycle. One is the last step of the power-on restore. The other is a host write that holds 0x0001 for the run address. The bench keeps that write asserted through the whole restore, so it must be ignored until the cycle in which busy has fallen. In that cycle it must be accepted and start the clear sweep. A cycle-level reference model built from queues predicts ownership of the port, address and data for every clock. Any write that leaks in early, or any cycle lost between the two walks, shows up as a mismatch.

// File: rtl/rce_pkg.sv
package rce_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        addr_t lo;
        addr_t hi;
    } win_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        data_t data;
    } wr_t;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_RESTORE = 2'd1,
        M_CLEAR   = 2'd2
    } mode_e;

    localparam int   N_RESTORE = 2;
    localparam win_t RESTORE_WIN [N_RESTORE] = '{
        '{lo: 12'h000, hi: 12'h0FF},
        '{lo: 12'h400, hi: 12'h5FF}
    };
    localparam win_t CLEAR_WIN = '{lo: 12'h200, hi: 12'h3FF};
    localparam addr_t BUF_BASE = 12'h800;

    function automatic logic in_win(addr_t a, win_t w);
        return (a >= w.lo) && (a <= w.hi);
    endfunction

endpackage

// File: rtl/rce_seq.sv
module rce_seq
    import rce_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output mode_e mode,
    output addr_t addr
);

    localparam int IW = (N_RESTORE > 1) ? $clog2(N_RESTORE) : 1;

    logic [IW-1:0] idx;
    logic [IW-1:0] idx_nx;
    logic          last_win;

    assign idx_nx   = idx + IW'(1);
    assign last_win = (idx == IW'(N_RESTORE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= M_RESTORE;
            idx  <= '0;
            addr <= RESTORE_WIN[0].lo;
        end else begin
            case (mode)
                M_RESTORE: begin
                    if (addr == RESTORE_WIN[idx].hi) begin
                        if (last_win) begin
                            mode <= M_IDLE;
                        end else begin
                            idx  <= idx_nx;
                            addr <= RESTORE_WIN[idx_nx].lo;
                        end
                    end else begin
                        addr <= addr + ADDR_W'(1);
                    end
                end
                M_CLEAR: begin
                    if (addr == CLEAR_WIN.hi) begin
                        mode <= M_IDLE;
                    end else begin
                        addr <= addr + ADDR_W'(1);
                    end
                end
                default: begin
                    if (start) begin
                        mode <= M_CLEAR;
                        addr <= CLEAR_WIN.lo;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/rce_run.sv
module rce_run
    import rce_pkg::*;
#(
    parameter addr_t RUN_ADDR  = 12'h680,
    parameter data_t RUN_START = 16'h0001
) (
    input  logic clk,
    input  logic rst,
    input  wr_t  acc,
    output logic start
);

    data_t run_q;
    logic  hit;

    assign hit   = acc.we && (acc.addr == RUN_ADDR);
    assign start = hit && (run_q == '0) && (acc.data == RUN_START);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (hit) begin
            run_q <= acc.data;
        end
    end

endmodule

// File: rtl/rce_mux.sv
module rce_mux
    import rce_pkg::*;
(
    input  mode_e mode,
    input  addr_t eng_addr,
    input  data_t dflt,
    input  wr_t   req,
    output wr_t   port,
    output logic  ready
);

    always_comb begin
        ready = (mode == M_IDLE);
        case (mode)
            M_RESTORE: port = '{we: 1'b1, addr: eng_addr, data: dflt};
            M_CLEAR:   port = '{we: 1'b1, addr: eng_addr, data: '0};
            default:   port = req;
        endcase
    end

endmodule

// File: rtl/reg_clear_engine.sv
module reg_clear_engine
    import rce_pkg::*;
#(
    parameter addr_t RUN_ADDR  = 12'h680,
    parameter data_t RUN_START = 16'h0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    input  logic [DATA_W-1:0] dflt_data,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              busy
);

    mode_e mode;
    addr_t eng_addr;
    logic  start;
    logic  ready;
    wr_t   req;
    wr_t   acc;
    wr_t   port;

    assign req = '{we: host_we, addr: host_addr, data: host_wdata};
    assign acc = '{we: host_we && ready, addr: host_addr, data: host_wdata};

    rce_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .mode  (mode),
        .addr  (eng_addr)
    );

    rce_run #(
        .RUN_ADDR  (RUN_ADDR),
        .RUN_START (RUN_START)
    ) u_run (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .start (start)
    );

    rce_mux u_mux (
        .mode     (mode),
        .eng_addr (eng_addr),
        .dflt     (dflt_data),
        .req      (req),
        .port     (port),
        .ready    (ready)
    );

    assign host_ready = ready;
    assign rf_we      = port.we;
    assign rf_waddr   = port.addr;
    assign rf_wdata   = port.data;
    assign busy       = (mode != M_IDLE);

endmodule

// File: rtl/rce_chk.sv
module rce_chk
    import rce_pkg::*;
#(
    parameter addr_t RUN_ADDR  = 12'h680,
    parameter data_t RUN_START = 16'h0001
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              host_ready,
    input logic              rf_we,
    input logic [ADDR_W-1:0] rf_waddr,
    input logic [DATA_W-1:0] rf_wdata,
    input logic              busy
);

    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(busy) && busy && ($past(rf_waddr) != RESTORE_WIN[0].hi)
        |-> rf_waddr == $past(rf_waddr) + ADDR_W'(1));

    p_window_jump_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(busy) && ($past(rf_waddr) == RESTORE_WIN[0].hi)
        |-> busy && (rf_waddr == RESTORE_WIN[1].lo));

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
        busy && in_win(rf_waddr, CLEAR_WIN) |-> rf_wdata == '0);

    p_sweep_origin_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(busy) && busy |-> rf_waddr == CLEAR_WIN.lo);

    p_no_start_r4: assert property (@(posedge clk) disable iff (rst)
        !busy && host_we && (host_addr == RUN_ADDR) && (host_wdata != RUN_START)
        |=> !busy);

    p_stall_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> rf_we && !host_ready);

    p_buffer_safe_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> rf_waddr < BUF_BASE);

endmodule

bind reg_clear_engine rce_chk #(
    .RUN_ADDR  (RUN_ADDR),
    .RUN_START (RUN_START)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_ready (host_ready),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .busy       (busy)
);

// File: tb/reg_clear_engine_test.sv
`timescale 1ns/1ps
module reg_clear_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ready;
    logic [15:0] dflt_data;
    logic        rf_we;
    logic [11:0] rf_waddr;
    logic [15:0] rf_wdata;
    logic        busy;

    always #5 clk = ~clk;

    function automatic logic [15:0] dflt_of(logic [11:0] a);
        return {a[3:0], a} ^ 16'h3C5A;
    endfunction

    assign dflt_data = dflt_of(rf_waddr);

    reg_clear_engine uut (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_ready (host_ready),
        .dflt_data  (dflt_data),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .busy       (busy)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    int exp_addr[$];
    bit exp_rest[$];
    int run_val   = 0;
    int buf_hits  = 0;
    int sweeps    = 0;

    task automatic chk(string req, logic [30:0] act, logic [30:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(bit r, bit we, int a, int d, string tag);
        logic [30:0] e;
        @(negedge clk);
        rst = r; host_we = we; host_addr = 12'(a); host_wdata = 16'(d);
        #1;
        if (!r) begin
            if (exp_addr.size() > 0) begin
                e = {1'b1, 1'b0, 1'b1, 12'(exp_addr[0]),
                     exp_rest[0] ? dflt_of(12'(exp_addr[0])) : 16'h0000};
                if (rf_waddr >= 12'h800) buf_hits++;
            end else begin
                e = {1'b0, 1'b1, we, we ? 12'(a) : rf_waddr, we ? 16'(d) : rf_wdata};
            end
            chk(tag, {busy, host_ready, rf_we, rf_waddr, rf_wdata}, e);
        end
        // predict the coming edge
        if (r) begin
            exp_addr.delete(); exp_rest.delete();
            for (int i = 12'h000; i <= 12'h0FF; i++) begin exp_addr.push_back(i); exp_rest.push_back(1'b1); end
            for (int i = 12'h400; i <= 12'h5FF; i++) begin exp_addr.push_back(i); exp_rest.push_back(1'b1); end
            run_val = 0;
        end else if (exp_addr.size() > 0) begin
            void'(exp_addr.pop_front()); void'(exp_rest.pop_front());
        end else if (we && a == 12'h680) begin
            if (run_val == 0 && d == 1) begin
                sweeps++;
                for (int i = 12'h200; i <= 12'h3FF; i++) begin exp_addr.push_back(i); exp_rest.push_back(1'b0); end
            end
            run_val = d;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R1");
        // R1: first cycle out of reset
        step(0, 1, 12'h680, 1, "R1");
        // R2 restore with a run write held high; R6 it must be ignored
        while (exp_addr.size() > 0) step(0, 1, 12'h680, 1, "R2 R6");
        // first idle cycle accepts the held write: R3 sweep starts
        step(0, 1, 12'h680, 1, "R3");
        while (exp_addr.size() > 0) step(0, 1, 12'h850, 16'hBEEF, "R3 R6");
        // idle pass-through, R5
        step(0, 1, 12'h850, 16'h1234, "R5");
        step(0, 0, 12'h000, 0, "R5");
        // R4: non-starting run writes
        step(0, 1, 12'h680, 1, "R4");
        step(0, 0, 0, 0, "R4");
        step(0, 1, 12'h680, 2, "R4");
        step(0, 1, 12'h680, 1, "R4");
        step(0, 0, 0, 0, "R4");
        step(0, 1, 12'h680, 0, "R4");
        step(0, 1, 12'h680, 0, "R4");
        step(0, 0, 0, 0, "R4");
        // R8: rearm and start again
        step(0, 1, 12'h680, 1, "R8");
        while (exp_addr.size() > 0) step(0, 0, 0, 0, "R8 R3");
        step(0, 0, 0, 0, "R8");
        // R7: engine never touched the buffer window
        chk("R7", 31'(buf_hits), 31'(0));
        chk("R8", 31'(sweeps), 31'(2));
        finish_run();
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule